// File: doc/BRIEF.md
# Shared-Line Serial Transmitter with Collision Readback

This block is the transmit half of an asynchronous serial port that shares one line with other senders, either a single wire or a wired-AND bus. Each frame holds a low start bit, seven, eight or nine data bits sent least significant first, and a high stop bit. The transmitter reads the line back on its receive pin and compares it with the level it is driving. Any difference raises a sticky collision flag. A configuration input can make the same event drop the transmit-enable bit, so the port leaves the bus immediately.

The comparison point is set by configuration. It is either the transfer-clock tick that ends each bit, or a strobe from an external one-shot timer, which lets the sample fall anywhere inside the bit. A frame starts in one of two ways. In the first, it starts on the first transfer-clock tick after transmit enable and a loaded word are both present. In the second, it waits for an edge on the receive line, which lets the frame lock onto another sender's activity. A polarity input inverts the transmit and receive line levels together. Every comparison and every edge decision uses the inverted levels.

Software, or a surrounding controller, loads a word while the block is not busy. It sets or clears transmit enable with pulses and clears the collision flag with a pulse. Baud generation and the one-shot timer are outside this block. They reach it as single-cycle enable pulses.

Top module: `shared_line_tx`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0, `coll_flag` is 0 and `tx_en` is 0.
- R2: A frame on `txd` has these logical levels: 0 for the start bit, then the data bits least significant first, then 1 for the stop bit. Each bit ends on a `bit_tick`. The data length follows `cfg_len`: 0 gives 7 bits, 1 gives 8, and 2 or 3 give 9. `busy` falls when the stop bit ends.
- R3: The physical level on `txd` equals the logical level XOR `cfg_invert`, so the idle line is `~cfg_invert`. `rxd` is interpreted with the same inversion.
- R4: With `cfg_edge_start`=0, the start bit appears on `txd` one clock after the first `bit_tick` that follows the cycle in which a word is pending and `tx_en` is 1. Until then, `txd` stays idle.
- R5: With `cfg_edge_start`=1, the start bit appears once a logical falling edge of `rxd` has passed the two-stage synchroniser. That edge is physically falling when `cfg_invert`=0 and rising when it is 1. An edge that occurs before the word is pending and `tx_en` is 1 is ignored.
- R6: With `cfg_sample_ext`=0, the line is compared only on `bit_tick` cycles during a frame. `ext_strobe` has no effect.
- R7: With `cfg_sample_ext`=1, the line is compared only on `ext_strobe` cycles during a frame. `bit_tick` does not sample.
- R8: A mismatch sets `coll_flag` on the next clock edge. The flag stays set until a `coll_clr` pulse. When a new mismatch and `coll_clr` fall in the same cycle, the flag stays set.
- R9: With `cfg_auto_off`=1, `tx_en` becomes 0 on the same clock edge that sets `coll_flag`. With `cfg_auto_off`=0, a collision leaves `tx_en` unchanged.
- R10: When `tx_en` is 0 during a frame, the frame is abandoned at the next `bit_tick`. `txd` returns to idle and `busy` falls, and the word is discarded.
- R11: With `rxd` looped back from `txd`, no collision is ever reported. The compare accounts for the two-flop receive latency.
- R12: `load_valid` loads `load_data` only while `busy` is 0. A load while busy is ignored.
- R13: `te_clr` takes priority over `te_set`, and a collision auto-clear takes priority over `te_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | Transfer-clock enable, one pulse per bit period |
| ext_strobe | input | 1 | External one-shot underflow sample strobe |
| cfg_sample_ext | input | 1 | 1: sample on `ext_strobe`; 0: sample on `bit_tick` |
| cfg_auto_off | input | 1 | 1: a collision clears transmit enable |
| cfg_edge_start | input | 1 | 1: start on a receive-line edge; 0: start on a tick |
| cfg_invert | input | 1 | Inverts the `txd` and `rxd` line levels |
| cfg_len | input | 2 | Data length code (0:7, 1:8, 2/3:9 bits) |
| te_set | input | 1 | Pulse that sets transmit enable |
| te_clr | input | 1 | Pulse that clears transmit enable |
| coll_clr | input | 1 | Pulse that clears the collision flag |
| load_valid | input | 1 | Load request for `load_data` |
| load_data | input | 9 | Word to transmit |
| rxd | input | 1 | Line level read back |
| txd | output | 1 | Driven line level |
| busy | output | 1 | A word is pending or being sent |
| coll_flag | output | 1 | Sticky collision flag |
| tx_en | output | 1 | Transmit enable |

## Verification
Two events can land in the same clock: a mismatch that raises the collision flag, and a software clear of that flag. The bench stops the free-running ticks during a frame and forces the read-back line to the opposite level. It then raises one manual `bit_tick` in the same cycle as `coll_clr`, and requires the flag to remain set afterwards. In the same way, a mismatch under automatic clearing is checked to drop transmit enable on the edge that raises the flag. The frame is then checked to end at the following tick instead of running to its stop bit.

// File: rtl/stx_pkg.sv
package stx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DLY  = 2'd1,
        ST_EDGE = 2'd2,
        ST_SEND = 2'd3
    } tx_state_e;

    // Data-bit count selected by the length code.
    function automatic logic [3:0] frame_len(input logic [1:0] code);
        case (code)
            2'd0:    frame_len = 4'd7;
            2'd1:    frame_len = 4'd8;
            default: frame_len = 4'd9;
        endcase
    endfunction

endpackage

// File: rtl/stx_sync.sv
module stx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    input  logic inv,
    output logic rx_line,
    output logic rx_fall
);
    typedef struct packed {
        logic [STAGES:0] chain;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d = q;
        d.chain = {q.chain[STAGES-1:0], rxd};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{chain: '1};
        else        q <= d;
    end

    assign rx_line = q.chain[STAGES-1];
    // logical 1 -> 0 between the previous and current synchronised sample
    assign rx_fall = (q.chain[STAGES] ^ inv) & ~(q.chain[STAGES-1] ^ inv);
endmodule

// File: rtl/stx_frame.sv
module stx_frame
    import stx_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic              edge_start,
    input  logic              start_edge,
    input  logic              inv,
    input  logic [1:0]        len,
    input  logic              load_valid,
    input  logic [DATA_W-1:0] load_data,
    output logic              txd,
    output logic              sending,
    output logic              busy
);
    localparam int CW = $clog2(DATA_W + 2);
    localparam int IW = $clog2(DATA_W);

    typedef struct packed {
        tx_state_e         state;
        logic [CW-1:0]     cnt;
        logic [DATA_W-1:0] data;
        logic              pend;
        logic              txd;
    } fr_t;

    fr_t q, d;
    logic [CW-1:0] last;
    logic [CW-1:0] idx;
    logic          lvl;

    always_comb begin
        d    = q;
        last = CW'(frame_len(len)) + CW'(1);
        unique case (q.state)
            ST_IDLE: begin
                if (!q.pend && load_valid) begin
                    d.pend = 1'b1;
                    d.data = load_data;
                end else if (q.pend && tx_en) begin
                    d.state = edge_start ? ST_EDGE : ST_DLY;
                end
            end
            ST_DLY: begin
                if (!tx_en) d.state = ST_IDLE;
                else if (bit_tick) begin
                    d.state = ST_SEND;
                    d.cnt   = '0;
                end
            end
            ST_EDGE: begin
                if (!tx_en) d.state = ST_IDLE;
                else if (start_edge) begin
                    d.state = ST_SEND;
                    d.cnt   = '0;
                end
            end
            ST_SEND: begin
                if (bit_tick) begin
                    if (!tx_en || q.cnt == last) begin
                        d.state = ST_IDLE;
                        d.pend  = 1'b0;
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase

        // Line level of the bit selected by the next state.
        idx = d.cnt - CW'(1);
        lvl = 1'b1;
        if (d.state == ST_SEND) begin
            if (d.cnt == '0)     lvl = 1'b0;
            else if (d.cnt < last) lvl = d.data[idx[IW-1:0]];
        end
        d.txd = lvl ^ inv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: ST_IDLE, cnt: '0, data: '0, pend: 1'b0, txd: 1'b1};
        else        q <= d;
    end

    assign txd     = q.txd;
    assign sending = (q.state == ST_SEND);
    assign busy    = q.pend;
endmodule

// File: rtl/stx_guard.sv
module stx_guard #(
    parameter int DELAY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd,
    input  logic sending,
    input  logic bit_tick,
    input  logic ext_strobe,
    input  logic sample_ext,
    input  logic rx_line,
    input  logic auto_off,
    input  logic coll_clr,
    input  logic te_set,
    input  logic te_clr,
    output logic coll_flag,
    output logic tx_en
);
    typedef struct packed {
        logic [DELAY-1:0] hist;
        logic             flag;
        logic             te;
    } gd_t;

    gd_t  q, d;
    logic point;
    logic hit;

    always_comb begin
        d      = q;
        d.hist = {q.hist[DELAY-2:0], txd};
        point  = sample_ext ? ext_strobe : bit_tick;
        // driven level aged by the receive synchroniser latency
        hit    = sending && point && (q.hist[DELAY-1] != rx_line);
        d.flag = hit | (q.flag & ~coll_clr);
        if (hit && auto_off) d.te = 1'b0;
        else if (te_clr)     d.te = 1'b0;
        else if (te_set)     d.te = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{hist: '1, flag: 1'b0, te: 1'b0};
        else        q <= d;
    end

    assign coll_flag = q.flag;
    assign tx_en     = q.te;
endmodule

// File: rtl/shared_line_tx.sv
module shared_line_tx #(
    parameter int DATA_W      = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              ext_strobe,
    input  logic              cfg_sample_ext,
    input  logic              cfg_auto_off,
    input  logic              cfg_edge_start,
    input  logic              cfg_invert,
    input  logic [1:0]        cfg_len,
    input  logic              te_set,
    input  logic              te_clr,
    input  logic              coll_clr,
    input  logic              load_valid,
    input  logic [DATA_W-1:0] load_data,
    input  logic              rxd,
    output logic              txd,
    output logic              busy,
    output logic              coll_flag,
    output logic              tx_en
);
    logic rx_line;
    logic rx_fall;
    logic sending;

    stx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rxd     (rxd),
        .inv     (cfg_invert),
        .rx_line (rx_line),
        .rx_fall (rx_fall)
    );

    stx_frame #(.DATA_W(DATA_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .tx_en      (tx_en),
        .edge_start (cfg_edge_start),
        .start_edge (rx_fall),
        .inv        (cfg_invert),
        .len        (cfg_len),
        .load_valid (load_valid),
        .load_data  (load_data),
        .txd        (txd),
        .sending    (sending),
        .busy       (busy)
    );

    stx_guard #(.DELAY(SYNC_STAGES)) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .txd        (txd),
        .sending    (sending),
        .bit_tick   (bit_tick),
        .ext_strobe (ext_strobe),
        .sample_ext (cfg_sample_ext),
        .rx_line    (rx_line),
        .auto_off   (cfg_auto_off),
        .coll_clr   (coll_clr),
        .te_set     (te_set),
        .te_clr     (te_clr),
        .coll_flag  (coll_flag),
        .tx_en      (tx_en)
    );
endmodule

// File: rtl/stx_checker.sv
module stx_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic ext_strobe,
    input logic cfg_sample_ext,
    input logic cfg_auto_off,
    input logic cfg_invert,
    input logic te_clr,
    input logic coll_clr,
    input logic busy,
    input logic txd,
    input logic coll_flag,
    input logic tx_en
);
    logic seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        coll_flag && !coll_clr |=> coll_flag);

    a_r9_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_auto_off && $rose(coll_flag) |-> !tx_en);

    a_r13_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
        te_clr |=> !tx_en);

    a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        seen && !busy && $stable(cfg_invert) |-> txd == ~cfg_invert);

    a_r6_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_sample_ext && !bit_tick |=> !$rose(coll_flag));

    a_r7_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sample_ext && !ext_strobe |=> !$rose(coll_flag));

    a_r10_flag_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coll_flag) |-> $past(busy));
endmodule

bind shared_line_tx stx_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bit_tick       (bit_tick),
    .ext_strobe     (ext_strobe),
    .cfg_sample_ext (cfg_sample_ext),
    .cfg_auto_off   (cfg_auto_off),
    .cfg_invert     (cfg_invert),
    .te_clr         (te_clr),
    .coll_clr       (coll_clr),
    .busy           (busy),
    .txd            (txd),
    .coll_flag      (coll_flag),
    .tx_en          (tx_en)
);

// File: tb/shared_line_tx_test.sv
`timescale 1ns/1ps
module shared_line_tx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0, ext_strobe = 1'b0;
    logic       cfg_sample_ext = 1'b0, cfg_auto_off = 1'b0, cfg_edge_start = 1'b0, cfg_invert = 1'b0;
    logic [1:0] cfg_len = 2'd1;
    logic       te_set = 1'b0, te_clr = 1'b0, coll_clr = 1'b0, load_valid = 1'b0;
    logic [8:0] load_data = '0;
    logic       flip = 1'b0, ovr_en = 1'b0, ovr_val = 1'b1;
    wire        rxd;
    wire        txd, busy, coll_flag, tx_en;

    assign rxd = ovr_en ? ovr_val : (txd ^ flip);

    always #2.5 clk = ~clk;

    shared_line_tx uut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ext_strobe(ext_strobe),
        .cfg_sample_ext(cfg_sample_ext), .cfg_auto_off(cfg_auto_off),
        .cfg_edge_start(cfg_edge_start), .cfg_invert(cfg_invert), .cfg_len(cfg_len),
        .te_set(te_set), .te_clr(te_clr), .coll_clr(coll_clr),
        .load_valid(load_valid), .load_data(load_data), .rxd(rxd),
        .txd(txd), .busy(busy), .coll_flag(coll_flag), .tx_en(tx_en)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int ph, idx, pend, dat, mtxd, mflag, mte;
    int rs1, rs2, rs3, th1, th2;
    int mn, mhit, medge, mlvl, mload;
    int cap[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; idx = 0; pend = 0; dat = 0; mtxd = 1; mflag = 0; mte = 0;
            rs1 = 1; rs2 = 1; rs3 = 1; th1 = 1; th2 = 1;
        end else begin
            if (ph == 3 && bit_tick) cap.push_back(int'(txd));
            mn    = (cfg_len == 2'd0) ? 7 : (cfg_len == 2'd1) ? 8 : 9;
            mhit  = (ph == 3 && (cfg_sample_ext ? ext_strobe : bit_tick) && th2 != rs2) ? 1 : 0;
            medge = (((rs3 ^ int'(cfg_invert)) == 1) && ((rs2 ^ int'(cfg_invert)) == 0)) ? 1 : 0;
            mload = 0;
            case (ph)
                0: if (pend == 0 && load_valid) mload = 1;
                   else if (pend == 1 && mte == 1) ph = cfg_edge_start ? 2 : 1;
                1: if (mte == 0) ph = 0; else if (bit_tick) begin ph = 3; idx = 0; end
                2: if (mte == 0) ph = 0; else if (medge == 1) begin ph = 3; idx = 0; end
                default: if (bit_tick) begin
                    if (mte == 0 || idx == mn + 1) begin ph = 0; pend = 0; end
                    else idx++;
                end
            endcase
            if (mload == 1) begin pend = 1; dat = int'(load_data); end
            if (mhit == 1 && cfg_auto_off) mte = 0;
            else if (te_clr) mte = 0;
            else if (te_set) mte = 1;
            mflag = (mhit == 1) ? 1 : (coll_clr ? 0 : mflag);
            mlvl = 1;
            if (ph == 3) begin
                if (idx == 0) mlvl = 0;
                else if (idx <= mn) mlvl = (dat >> (idx - 1)) & 1;
            end
            th2 = th1; th1 = mtxd;
            rs3 = rs2; rs2 = rs1; rs1 = int'(rxd);
            mtxd = mlvl ^ int'(cfg_invert);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 txd vs model", int'(txd), mtxd);
            chk("R8 coll_flag vs model", int'(coll_flag), mflag);
            chk("R9 tx_en vs model", int'(tx_en), mte);
            chk("R12 busy vs model", int'(busy), pend);
        end
    end

    // ---------------- tick generator ----------------
    bit tick_run = 1'b0;
    int tcnt = 0;
    always @(negedge clk) begin
        if (tick_run) begin
            tcnt = (tcnt == 7) ? 0 : tcnt + 1;
            bit_tick = (tcnt == 0);
        end
    end

    task automatic stop_ticks();
        @(negedge clk); tick_run = 1'b0; bit_tick = 1'b0;
    endtask
    task automatic start_ticks();
        @(negedge clk); tcnt = 0; tick_run = 1'b1; bit_tick = 1'b0;
    endtask
    task automatic manual_tick();
        @(negedge clk); bit_tick = 1'b1;
        @(negedge clk); bit_tick = 1'b0;
    endtask
    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic pulse_te_set();
        @(negedge clk); te_set = 1'b1; @(negedge clk); te_set = 1'b0;
    endtask
    task automatic pulse_clr();
        @(negedge clk); coll_clr = 1'b1; @(negedge clk); coll_clr = 1'b0;
    endtask
    task automatic send(input logic [8:0] d);
        @(negedge clk); load_valid = 1'b1; load_data = d;
        @(negedge clk); load_valid = 1'b0;
    endtask
    task automatic wait_idle(input string tag);
        int n = 0;
        while (busy && n < 400) begin @(negedge clk); n++; end
        chk(tag, int'(busy), 0);
    endtask
    task automatic check_cap(input string tag, input int d, input int n, input int inv);
        chk({tag, " bit count"}, cap.size(), n + 2);
        if (cap.size() == n + 2) begin
            chk({tag, " start bit"}, cap[0] ^ inv, 0);
            for (int i = 0; i < n; i++) chk({tag, " data bit"}, cap[i + 1] ^ inv, (d >> i) & 1);
            chk({tag, " stop bit"}, cap[n + 1] ^ inv, 1);
        end
    endtask
    task automatic run_frame(input string tag, input int d, input logic [1:0] len, input int n);
        cfg_len = len;
        cap.delete();
        send(9'(d));
        wait_idle({tag, " frame ends"});
        check_cap(tag, d, n, int'(cfg_invert));
        chk("R11 no collision on loopback", int'(coll_flag), 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        cycles(3);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset txd", int'(txd), 1);
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset coll_flag", int'(coll_flag), 0);
        chk("R1 reset tx_en", int'(tx_en), 0);

        // R13: clear beats set in the same cycle
        @(negedge clk); te_set = 1'b1; te_clr = 1'b1;
        @(negedge clk); te_set = 1'b0; te_clr = 1'b0;
        chk("R13 te_clr wins over te_set", int'(tx_en), 0);
        pulse_te_set();
        chk("R13 te_set alone", int'(tx_en), 1);

        // R4: delayed start needs a tick
        cap.delete();
        cfg_len = 2'd1;
        send(9'h0A5);
        cycles(5);
        chk("R4 idle before tick", int'(txd), 1);
        chk("R4 busy while waiting", int'(busy), 1);
        manual_tick();
        chk("R4 start bit after tick", int'(txd), 0);
        start_ticks();
        wait_idle("R2 8-bit frame ends");
        check_cap("R2 8-bit", 'hA5, 8, 0);
        chk("R11 no collision 8-bit", int'(coll_flag), 0);

        run_frame("R2 7-bit", 'h35, 2'd0, 7);
        run_frame("R2 9-bit", 'h1C3, 2'd2, 9);

        // R3: inverted line
        @(negedge clk); cfg_invert = 1'b1;
        cycles(4);
        chk("R3 inverted idle level", int'(txd), 0);
        run_frame("R3 inverted 8-bit", 'h5A, 2'd1, 8);
        @(negedge clk); cfg_invert = 1'b0;
        cycles(4);

        // R12: load while busy is ignored
        cap.delete();
        cfg_len = 2'd1;
        send(9'h011);
        cycles(10);
        send(9'h022);
        wait_idle("R12 first frame ends");
        check_cap("R12 first word kept", 'h11, 8, 0);
        cycles(20);
        chk("R12 second load dropped", int'(busy), 0);

        // R6/R8: tick sampling, strobe ignored, same-cycle set and clear
        send(9'h0FF);
        cycles(20);
        stop_ticks();
        @(negedge clk); flip = 1'b1;
        cycles(4);
        @(negedge clk); ext_strobe = 1'b1; @(negedge clk); ext_strobe = 1'b0;
        chk("R6 strobe ignored in tick mode", int'(coll_flag), 0);
        manual_tick();
        chk("R6 tick samples mismatch", int'(coll_flag), 1);
        chk("R9 auto off keeps tx_en", int'(tx_en), 1);
        @(negedge clk); bit_tick = 1'b1; coll_clr = 1'b1;
        @(negedge clk); bit_tick = 1'b0; coll_clr = 1'b0;
        chk("R8 set wins over clear", int'(coll_flag), 1);
        cycles(6);
        chk("R8 flag sticky", int'(coll_flag), 1);
        pulse_clr();
        chk("R8 clear pulse", int'(coll_flag), 0);
        @(negedge clk); flip = 1'b0;
        cycles(4);
        start_ticks();
        wait_idle("R9 frame completes without auto off");

        // R7: strobe sampling
        @(negedge clk); cfg_sample_ext = 1'b1;
        send(9'h0C3);
        cycles(15);
        @(negedge clk); flip = 1'b1;
        cycles(30);
        chk("R7 ticks do not sample", int'(coll_flag), 0);
        @(negedge clk); ext_strobe = 1'b1; @(negedge clk); ext_strobe = 1'b0;
        chk("R7 strobe samples mismatch", int'(coll_flag), 1);
        @(negedge clk); flip = 1'b0;
        wait_idle("R7 frame ends");
        pulse_clr();
        @(negedge clk); cfg_sample_ext = 1'b0;

        // R9/R10: auto-clear aborts the frame
        @(negedge clk); cfg_auto_off = 1'b1;
        send(9'h00F);
        cycles(20);
        @(negedge clk); flip = 1'b1;
        cycles(12);
        @(negedge clk); flip = 1'b0;
        chk("R9 collision flagged", int'(coll_flag), 1);
        chk("R9 auto clear of tx_en", int'(tx_en), 0);
        cycles(12);
        chk("R10 frame abandoned", int'(busy), 0);
        chk("R10 line idle after abort", int'(txd), 1);
        @(negedge clk); cfg_auto_off = 1'b0;
        pulse_clr();
        pulse_te_set();

        // R10: software disable mid-frame
        send(9'h155);
        cycles(20);
        @(negedge clk); te_clr = 1'b1; @(negedge clk); te_clr = 1'b0;
        cycles(10);
        chk("R10 te_clr abandons frame", int'(busy), 0);
        chk("R10 idle after te_clr", int'(txd), 1);

        // R5: edge start, early edge ignored
        @(negedge clk); cfg_edge_start = 1'b1; cfg_sample_ext = 1'b1; ovr_en = 1'b1; ovr_val = 1'b1;
        cap.delete();
        send(9'h0B6);
        cycles(3);
        @(negedge clk); ovr_val = 1'b0;
        cycles(4);
        @(negedge clk); ovr_val = 1'b1;
        cycles(4);
        pulse_te_set();
        cycles(10);
        chk("R5 early edge ignored busy", int'(busy), 1);
        chk("R5 early edge ignored line", int'(txd), 1);
        @(negedge clk); ovr_val = 1'b0;
        cycles(4);
        chk("R5 start on edge", int'(txd), 0);
        @(negedge clk); ovr_en = 1'b0;
        wait_idle("R5 edge frame ends");
        check_cap("R5 edge frame", 'hB6, 8, 0);
        chk("R11 no collision edge frame", int'(coll_flag), 0);
        @(negedge clk); cfg_edge_start = 1'b0; cfg_sample_ext = 1'b0;
        cycles(4);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule